// File: doc/BRIEF.md
# Serial Bit-Clock Generator

This block produces the bit clock for a synchronous serial port, together with single-cycle strobes that mark each edge of that clock. It lives entirely in the system clock domain. The clock is built by counting input ticks. A tick comes either from a fixed divide-by-four of the system clock or from one period of an external reference clock, which is brought into the domain through a two-stage synchronizer. An 8-bit divide setting selects how many ticks the high and low phases each last.

A polarity control inverts the produced clock, and the edge strobes always describe the clock as it appears at the output. A shift register that sits alongside pulls bits out on the rising strobe. For the first bit of a frame it waits for a separate launch strobe instead. That launch strobe follows a frame-start pulse and can be pushed back by a fixed number of system cycles.

Top module: `bitclk_gen`

## Requirements
- R1: While `rst_n` is low, `bclk`, `rise_stb`, `fall_stb` and `launch_stb` are all low. After release, with `inv_pol` = 0, the first transition of `bclk` is a rise.
- R2: With `src_int` = 1, one input tick lasts 4 system clock cycles.
- R3: For an even, nonzero divide value D, the clock is high for D/2+1 ticks and low for D/2 ticks.
- R4: For an odd divide value D, the high phase and the low phase each last (D+1)/2 ticks.
- R5: For D = 0, the clock toggles on every half tick. On the internal source this gives 2 cycles high and 2 cycles low. On the external source it toggles on each synchronized edge of `ext_clk`.
- R6: With `src_int` = 0, one input tick is one period of `ext_clk`, counted between rising edges after synchronization.
- R7: With `inv_pol` = 1, `bclk` is inverted. The high phase then lasts as long as the low-phase count, and the strobes follow the inverted clock.
- R8: `rise_stb` is high for exactly the one cycle in which `bclk` first reads 1 after reading 0. `fall_stb` behaves the same way for the 1-to-0 change. The two are never high together.
- R9: A new divide value takes effect only when a low phase ends. A phase already in progress keeps the length it started with.
- R10: With `launch_dly_en` = 0, `launch_stb` pulses in the same cycle as the first `rise_stb` after a `frame_start` pulse.
- R11: With `launch_dly_en` = 1, `launch_stb` pulses exactly LAUNCH_DLY system cycles (default 6, allowed range 4 to 8) after that first `rise_stb`.
- R12: One `frame_start` pulse gives exactly one `launch_stb` pulse. Later rising edges produce no launch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_int | input | 1 | 1: internal divide-by-4 tick; 0: external clock tick |
| ext_clk | input | 1 | External reference clock, asynchronous |
| div_val | input | DIV_W | Divide value D |
| inv_pol | input | 1 | Invert the output clock |
| launch_dly_en | input | 1 | Add the fixed delay to the first-bit launch |
| frame_start | input | 1 | One-cycle pulse that arms the first-bit launch |
| bclk | output | 1 | Generated bit clock |
| rise_stb | output | 1 | One-cycle pulse on each rise of `bclk` |
| fall_stb | output | 1 | One-cycle pulse on each fall of `bclk` |
| launch_stb | output | 1 | One-cycle first-bit launch pulse |

## Verification
Faults in the phase counter or the loaded divide value appear as wrong high and low run lengths at `bclk`. They show within one output period, so the bench measures the distance in cycles between successive strobes for every small divide value and for the extremes. Faults in the tick source show as every measured length scaled wrongly, again within the first period. Faults in the launch state show up within one bit period: a missing, early or repeated `launch_stb` is visible against the first `rise_stb` after `frame_start`.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
    // Internal tick spacing in system cycles.
    localparam int INT_TICK_CYCLES = 4;
    // Which level the unpolarized clock holds.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/bclk_tick_src.sv
module bclk_tick_src #(
    parameter int PRESCALE    = bclk_pkg::INT_TICK_CYCLES,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_int,
    input  logic ext_clk,
    output logic tick,
    output logic half_tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [PW-1:0] PRE_MID  = PW'(PRESCALE / 2 - 1);

    typedef struct packed {
        logic [PW-1:0]          pre;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } st_t;

    st_t  s_d, s_q;
    logic ext_lvl, ext_rise, ext_fall, int_full, int_half;

    always_comb begin
        ext_lvl  = s_q.sync[SYNC_STAGES-1];
        ext_rise = ext_lvl & ~s_q.prev;
        ext_fall = ~ext_lvl & s_q.prev;
        int_full = (s_q.pre == PRE_LAST);
        int_half = int_full | (s_q.pre == PRE_MID);

        s_d      = s_q;
        s_d.pre  = int_full ? '0 : s_q.pre + 1'b1;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], ext_clk};
        s_d.prev = ext_lvl;

        tick      = sel_int ? int_full : ext_rise;
        half_tick = sel_int ? int_half : (ext_rise | ext_fall);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bclk_phase_gen.sv
module bclk_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             half_tick,
    input  logic [DIV_W-1:0] div_in,
    output logic             running,
    output logic             level
);
    import bclk_pkg::*;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic             run;
        lvl_e             lvl;
        logic [DIV_W-1:0] left;
        logic [DIV_W-1:0] div;
    } st_t;

    st_t              s_d, s_q;
    logic [DIV_W-1:0] sel_div;
    logic             step;

    // High phase: D/2+1 for even, (D+1)/2 for odd, 1 for zero -> (D>>1)+1 in all cases.
    function automatic logic [DIV_W-1:0] high_ticks(input logic [DIV_W-1:0] d);
        return (d >> 1) + ONE;
    endfunction

    // Low phase: D/2 for even nonzero, (D+1)/2 for odd, 1 for zero.
    function automatic logic [DIV_W-1:0] low_ticks(input logic [DIV_W-1:0] d);
        if (d == '0) return ONE;
        return (d >> 1) + {{(DIV_W-1){1'b0}}, d[0]};
    endfunction

    always_comb begin
        sel_div = s_q.run ? s_q.div : div_in;
        step    = (sel_div == '0) ? half_tick : tick;
        s_d     = s_q;
        if (step) begin
            if (!s_q.run) begin
                s_d.run  = 1'b1;
                s_d.lvl  = LVL_HIGH;
                s_d.div  = div_in;
                s_d.left = high_ticks(div_in);
            end else if (s_q.left == ONE) begin
                if (s_q.lvl == LVL_HIGH) begin
                    s_d.lvl  = LVL_LOW;
                    s_d.left = low_ticks(s_q.div);
                end else begin
                    // End of a full low phase: the only point a new divide is taken.
                    s_d.lvl  = LVL_HIGH;
                    s_d.div  = div_in;
                    s_d.left = high_ticks(div_in);
                end
            end else begin
                s_d.left = s_q.left - ONE;
            end
        end
        running = s_q.run;
        level   = (s_q.lvl == LVL_HIGH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bclk_launch_ctl.sv
module bclk_launch_ctl #(
    parameter int LAUNCH_DLY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic dly_en,
    input  logic rise_evt,
    output logic launch
);
    localparam int CW = $clog2(LAUNCH_DLY + 1);
    localparam logic [CW-1:0] DLY_INIT = CW'(LAUNCH_DLY - 1);

    typedef struct packed {
        logic          armed;
        logic          pend;
        logic [CW-1:0] cnt;
        logic          fire;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (s_q.pend) begin
            if (s_q.cnt == '0) begin
                s_d.fire = 1'b1;
                s_d.pend = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (s_q.armed && rise_evt) begin
            s_d.armed = 1'b0;
            if (dly_en) begin
                s_d.pend = 1'b1;
                s_d.cnt  = DLY_INIT;
            end else begin
                s_d.fire = 1'b1;
            end
        end
        if (frame_start) s_d.armed = 1'b1;
        launch = s_q.fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
    parameter int DIV_W       = 8,
    parameter int PRESCALE    = bclk_pkg::INT_TICK_CYCLES,
    parameter int SYNC_STAGES = 2,
    parameter int LAUNCH_DLY  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_int,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div_val,
    input  logic             inv_pol,
    input  logic             launch_dly_en,
    input  logic             frame_start,
    output logic             bclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             launch_stb
);
    typedef struct packed {
        logic bclk;
        logic rise;
        logic fall;
    } out_t;

    out_t o_d, o_q;
    logic tick, half_tick, running, level;

    bclk_tick_src #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_int   (src_int),
        .ext_clk   (ext_clk),
        .tick      (tick),
        .half_tick (half_tick)
    );

    bclk_phase_gen #(
        .DIV_W (DIV_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .half_tick (half_tick),
        .div_in    (div_val),
        .running   (running),
        .level     (level)
    );

    always_comb begin
        o_d.bclk = running & (level ^ inv_pol);
        o_d.rise = o_d.bclk & ~o_q.bclk;
        o_d.fall = ~o_d.bclk & o_q.bclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    bclk_launch_ctl #(
        .LAUNCH_DLY (LAUNCH_DLY)
    ) u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .dly_en      (launch_dly_en),
        .rise_evt    (o_d.rise),
        .launch      (launch_stb)
    );

    assign bclk     = o_q.bclk;
    assign rise_stb = o_q.rise;
    assign fall_stb = o_q.fall;
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk,
    input logic rise_stb,
    input logic fall_stb,
    input logic launch_stb
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!bclk && !rise_stb && !fall_stb && !launch_stb));

    assert_rise_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (bclk && !$past(bclk)));

    assert_fall_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!bclk && $past(bclk)));

    assert_edge_has_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && !$past(bclk)) |-> rise_stb);

    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    assert_launch_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> !launch_stb);
endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .launch_stb (launch_stb)
);

// File: tb/bitclk_gen_test.sv
`timescale 1ns/1ps
module bitclk_gen_test;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_int = 1'b1;
    logic       ext_clk = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       inv_pol = 1'b0;
    logic       launch_dly_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       bclk, rise_stb, fall_stb, launch_stb;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    bitclk_gen #(.LAUNCH_DLY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .src_int(src_int), .ext_clk(ext_clk),
        .div_val(div_val), .inv_pol(inv_pol), .launch_dly_en(launch_dly_en),
        .frame_start(frame_start), .bclk(bclk), .rise_stb(rise_stb),
        .fall_stb(fall_stb), .launch_stb(launch_stb)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_edge(input bit want_rise, output int t);
        do @(negedge clk); while (want_rise ? !rise_stb : !fall_stb);
        t = cyc;
    endtask

    task automatic measure(output int hi, output int lo);
        int t0, t1, t2;
        wait_edge(1'b1, t0);
        wait_edge(1'b0, t1);
        wait_edge(1'b1, t2);
        hi = t1 - t0;
        lo = t2 - t1;
    endtask

    function automatic int hi_ticks(input int d);
        return d / 2 + 1;
    endfunction

    function automatic int lo_ticks(input int d);
        if (d == 0) return 1;
        return (d % 2 == 0) ? d / 2 : (d + 1) / 2;
    endfunction

    task automatic sweep_one(input int d, input int tick_len, input string req);
        int hi, lo, eh, el;
        div_val = 8'(d);
        measure(hi, lo);
        measure(hi, lo);
        if (d == 0) begin
            eh = tick_len / 2; el = tick_len / 2;
        end else begin
            eh = hi_ticks(d) * tick_len; el = lo_ticks(d) * tick_len;
        end
        chk(hi == eh, req, hi, eh);
        chk(lo == el, req, lo, el);
    endtask

    initial begin
        int t0, t1, t2, tl, extra, hi, lo;
        bit seen;

        // R1: reset state
        repeat (10) @(negedge clk);
        chk(bclk == 1'b0, "R1 bclk in reset", bclk, 0);
        chk(rise_stb == 1'b0 && fall_stb == 1'b0, "R1 strobes in reset", rise_stb | fall_stb, 0);
        chk(launch_stb == 1'b0, "R1 launch in reset", launch_stb, 0);
        div_val = 8'd3;
        rst_n = 1'b1;
        do @(negedge clk); while (!rise_stb && !fall_stb);
        chk(rise_stb == 1'b1, "R1 first edge is rise", rise_stb, 1);

        // R2 R3 R4 R5: internal source sweep
        for (int d = 0; d <= 40; d++)
            sweep_one(d, 4, (d == 0) ? "R5 internal D=0" : ((d % 2 == 0) ? "R3 even R2" : "R4 odd R2"));
        sweep_one(127, 4, "R4 odd large");
        sweep_one(128, 4, "R3 even large");
        sweep_one(254, 4, "R3 even max");
        sweep_one(255, 4, "R4 odd max");

        // R9: divide change lands only at the end of a low phase
        div_val = 8'd6;
        measure(hi, lo);
        wait_edge(1'b1, t0);
        div_val = 8'd10;
        wait_edge(1'b0, t1);
        chk(t1 - t0 == 16, "R9 old high kept", t1 - t0, 16);
        wait_edge(1'b1, t2);
        chk(t2 - t1 == 12, "R9 old low kept", t2 - t1, 12);
        wait_edge(1'b0, t1);
        chk(t1 - t2 == 24, "R9 new high", t1 - t2, 24);

        // R7 R8: polarity inversion
        div_val = 8'd4;
        inv_pol = 1'b1;
        measure(hi, lo);
        wait_edge(1'b1, t0);
        chk(bclk == 1'b1, "R8 bclk high at rise strobe", bclk, 1);
        wait_edge(1'b0, t1);
        chk(bclk == 1'b0, "R8 bclk low at fall strobe", bclk, 0);
        wait_edge(1'b1, t2);
        chk(t1 - t0 == 8, "R7 inverted high", t1 - t0, 8);
        chk(t2 - t1 == 12, "R7 inverted low", t2 - t1, 12);
        inv_pol = 1'b0;
        measure(hi, lo);
        chk(hi == 12, "R7 normal high restored", hi, 12);

        // R6 R5: external source, 6-cycle period
        src_int = 1'b0;
        for (int d = 0; d <= 8; d++)
            sweep_one(d, 6, (d == 0) ? "R5 external D=0" : "R6 external tick");
        src_int = 1'b1;

        // R10 R12: undelayed first-bit launch
        div_val = 8'd4;
        measure(hi, lo);
        launch_dly_en = 1'b0;
        wait_edge(1'b0, t1);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        seen = 1'b0;
        while (!rise_stb) begin
            if (launch_stb) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R10 no early launch", seen, 0);
        chk(launch_stb == 1'b1, "R10 launch with first rise", launch_stb, 1);
        extra = 0;
        repeat (60) begin
            @(negedge clk);
            if (launch_stb) extra++;
        end
        chk(extra == 0, "R12 single launch", extra, 0);

        // R11 R12: delayed first-bit launch
        launch_dly_en = 1'b1;
        wait_edge(1'b0, t1);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        wait_edge(1'b1, t0);
        chk(launch_stb == 1'b0, "R11 not at rise", launch_stb, 0);
        do @(negedge clk); while (!launch_stb && cyc - t0 < 40);
        tl = cyc;
        chk(tl - t0 == DLY, "R11 launch offset", tl - t0, DLY);
        extra = 0;
        repeat (60) begin
            @(negedge clk);
            if (launch_stb) extra++;
        end
        chk(extra == 0, "R12 single delayed launch", extra, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule